// File: doc/BRIEF.md
# Bus Port Integrity Guard

This block sits beside one request/grant/response memory port of a processor core and protects it against glitches and protocol corruption. On the request side it produces an odd parity bit for the request strobe and a 12-bit address-phase checksum. The checksum covers the address, the protection and memory-type attributes, the byte enables and write enable, the debug flag, the atomic opcode and the write data. On the incoming side it checks the parity that travels with the grant and the response-valid strobes. It also checks a 5-bit response checksum that covers the read data and the error/exclusive-okay flags.

Checking is enabled at two levels. A global enable and a per-access attribute must both be 1. The result is captured when each transaction is granted and kept in a small queue of outstanding transactions. The queue also records whether each transaction is a read or a write, so the read-data part of the response checksum is judged only for reads. A response that arrives while nothing is outstanding is an orphan. It raises the major alert directly.

Errors are reported in the same cycle as the offending bus values. `integ_err_o` flags parity and checksum mismatches. `alert_major_o` is high for every cycle in which either a mismatch or an orphan response is present. A parameter selects an instruction-port variant, which fixes the write-only fields of the checksum to constants.

Top module: `bus_integrity_guard`

## Requirements
- R1: `reqpar_o` is always the inverse of `req_i`, so that the pair carries odd parity.
- R2: For n = 0..3, `achk_o[n]` is the XOR of address byte n (`addr_i[8n+7:8n]`), which is even parity.
- R3: `achk_o[4]` is the XNOR over `prot_i` and `memtype_i`, and `achk_o[5]` is the XNOR over `be_i` and `we_i` (both odd parity). `achk_o[6]` is `~dbg_i`, and `achk_o[7]` is the XOR over `atop_i` (even parity).
- R4: For n = 0..3, `achk_o[8+n]` is the XOR of write-data byte n. It is computed from the full `wdata_i` whatever the values of `we_i` and `be_i`.
- R5: While `req_i`=1, `integ_en_i`=1 and `attr_integ_i`=1, a `gntpar_i` equal to `gnt_i` sets `integ_err_o` in that same cycle.
- R6: While the oldest outstanding transaction has checking enabled, an `rvalidpar_i` equal to `rvalid_i` sets `integ_err_o` in that cycle. This holds in every cycle, whether a response is present or not.
- R7: When a response arrives for an enabled transaction, a `rchk_i[4]` that differs from `err_i ^ exokay_i` sets `integ_err_o`. For a read transaction, a `rchk_i[3:0]` that differs from the byte-wise XOR of `rdata_i` also sets it. For a write transaction, `rchk_i[3:0]` is ignored.
- R8: The enable for each transaction is `integ_en_i & attr_integ_i`, sampled in its grant cycle. Later changes to `integ_en_i` do not alter it, and a transaction sampled as disabled never raises `integ_err_o`.
- R9: A grant (`req_i & gnt_i`) adds one outstanding transaction and a response (`rvalid_i`) retires the oldest one. Responses are matched to transactions in grant order. At most DEPTH (default 2) transactions are held, and a grant that arrives while the queue is full and no response is present is not recorded.
- R10: An `rvalid_i` that arrives while no transaction is outstanding sets `alert_major_o` in that cycle. It performs no parity or checksum check and leaves the outstanding count at zero. A grant in the same cycle is still recorded.
- R11: `alert_major_o` equals `integ_err_o` OR the orphan-response condition, in the same cycle.
- R12: With INSTR_PORT=1, the checksum treats the byte enables as 4'b1111, write enable as 0, atop as 0 and write data as 0. So `achk_o[5]`=1, `achk_o[7]`=0 and `achk_o[11:8]`=0 whatever those inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| integ_en_i | input | 1 | Global integrity-check enable |
| attr_integ_i | input | 1 | Per-access integrity attribute of the current request |
| req_i | input | 1 | Request strobe |
| gnt_i | input | 1 | Grant strobe |
| gntpar_i | input | 1 | Odd-parity companion of the grant |
| addr_i | input | 32 | Request address |
| prot_i | input | 3 | Protection attributes |
| memtype_i | input | 2 | Memory-type attributes |
| be_i | input | 4 | Byte enables |
| we_i | input | 1 | Write enable |
| dbg_i | input | 1 | Debug-mode access flag |
| atop_i | input | 6 | Atomic opcode |
| wdata_i | input | 32 | Write data |
| rvalid_i | input | 1 | Response-valid strobe |
| rvalidpar_i | input | 1 | Odd-parity companion of response valid |
| rdata_i | input | 32 | Read data |
| err_i | input | 1 | Response error flag |
| exokay_i | input | 1 | Exclusive-okay flag |
| rchk_i | input | 5 | Response checksum |
| reqpar_o | output | 1 | Odd-parity companion of the request |
| achk_o | output | 12 | Address-phase checksum |
| integ_err_o | output | 1 | Parity or checksum mismatch this cycle |
| alert_major_o | output | 1 | Major security alert |

## Verification
Two pairs of functions can fall in the same cycle. The first is an orphan response arriving together with a new grant. The bench starts with an empty queue and drives rvalid and a grant in one cycle. It expects the alert without an integrity error, and then expects the next response to be accepted as a normal one rather than an orphan. The second is a response retiring one entry while a grant adds another. The bench provokes this with one transaction outstanding. It judges the result by counting how many further responses pass before an orphan alert appears, and by checking that the per-transaction enables still match in grant order.

// File: rtl/bi_pkg.sv
// Package: shared widths, the queued transaction record and a byte-parity helper.
// Assumes a 32-bit address and data path, as the checksum layout requires.
package bi_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NBYTES  = DATA_W / 8;
    localparam int unsigned ACHK_W  = 12;
    localparam int unsigned RCHK_W  = NBYTES + 1;

    // Attributes remembered for each granted transaction
    typedef struct packed {
        logic is_write;
        logic chk_en;
    } txn_t;

    // Even parity (XOR) of every byte of a 32-bit word
    function automatic logic [NBYTES-1:0] byte_xor(input logic [DATA_W-1:0] w);
        logic [NBYTES-1:0] p;
        for (int b = 0; b < NBYTES; b++) begin
            p[b] = ^w[8*b +: 8];
        end
        return p;
    endfunction
endpackage

// File: rtl/bi_achk_gen.sv
// Address-phase checksum generator.
// Purely combinational. With INSTR_PORT=1 the write-side fields are replaced
// by fixed values, and the related inputs are not used.
module bi_achk_gen
    import bi_pkg::*;
#(
    parameter bit INSTR_PORT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        prot_i,
    input  logic [1:0]        memtype_i,
    input  logic [3:0]        be_i,
    input  logic              we_i,
    input  logic              dbg_i,
    input  logic [5:0]        atop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ACHK_W-1:0] achk_o
);
    logic [3:0]        be_eff;
    logic              we_eff;
    logic [5:0]        atop_eff;
    logic [DATA_W-1:0] wdata_eff;

    // Select the field values that enter the checksum for this port kind
    generate
        if (INSTR_PORT) begin : g_instr
            assign be_eff    = 4'b1111;
            assign we_eff    = 1'b0;
            assign atop_eff  = '0;
            assign wdata_eff = '0;
        end else begin : g_data
            assign be_eff    = be_i;
            assign we_eff    = we_i;
            assign atop_eff  = atop_i;
            assign wdata_eff = wdata_i;
        end
    endgenerate

    // Assemble the checksum, mixing even and odd parity conventions per field
    always_comb begin
        achk_o[3:0]  = byte_xor(addr_i);
        achk_o[4]    = ~^{prot_i, memtype_i};
        achk_o[5]    = ~^{be_eff, we_eff};
        achk_o[6]    = ~dbg_i;
        achk_o[7]    = ^atop_eff;
        achk_o[11:8] = byte_xor(wdata_eff);
    end
endmodule

// File: rtl/bi_txn_fifo.sv
// Outstanding-transaction queue.
// Pushes on an accepted grant, pops on a response and flags responses that
// arrive while empty. Assumes DEPTH >= 1, and that a grant arriving while the
// queue is full without a pop in the same cycle is not recorded.
module bi_txn_fifo
    import bi_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  txn_t push_data_i,
    input  logic rvalid_i,
    output logic pending_o,
    output txn_t head_o,
    output logic orphan_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    txn_t             mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop, do_push, full;

    // Derive occupancy flags and the effective push/pop strobes
    always_comb begin
        pending_o = (cnt_q != '0);
        full      = (cnt_q == CNT_W'(DEPTH));
        pop       = rvalid_i & pending_o;
        orphan_o  = rvalid_i & ~pending_o;
        do_push   = push_i & (~full | pop);
        head_o    = mem_q[rd_q];
    end

    // Advance pointers and occupancy count
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)     rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Store attributes of each newly granted transaction
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (do_push) begin
            mem_q[wr_q] <= push_data_i;
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(DEPTH));

    assert_cnt_grows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !full && !rvalid_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_orphan_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (orphan_o && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bi_rsp_check.sv
// Response-side integrity checker.
// Judges response-valid parity and the response checksum against the
// attributes of the oldest outstanding transaction. Assumes head_i is only
// meaningful while pending_i is 1.
module bi_rsp_check
    import bi_pkg::*;
(
    input  logic              pending_i,
    input  txn_t              head_i,
    input  logic              rvalid_i,
    input  logic              rvalidpar_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              err_i,
    input  logic              exokay_i,
    input  logic [RCHK_W-1:0] rchk_i,
    output logic              bad_o
);
    logic [RCHK_W-1:0] rchk_exp;
    logic              armed, par_bad, flag_bad, data_bad;

    // Compare incoming parity and checksum with the expected values
    always_comb begin
        rchk_exp = {err_i ^ exokay_i, byte_xor(rdata_i)};
        armed    = pending_i & head_i.chk_en;
        par_bad  = armed & (rvalidpar_i == rvalid_i);
        flag_bad = armed & rvalid_i & (rchk_i[RCHK_W-1] != rchk_exp[RCHK_W-1]);
        data_bad = armed & rvalid_i & ~head_i.is_write
                   & (rchk_i[NBYTES-1:0] != rchk_exp[NBYTES-1:0]);
        bad_o    = par_bad | flag_bad | data_bad;
    end
endmodule

// File: rtl/bus_integrity_guard.sv
// Bus port integrity guard.
// Generates request parity and the address-phase checksum, checks grant
// parity, response parity and the response checksum, and detects orphan
// responses. Assumes a response is never returned in its own grant cycle.
module bus_integrity_guard
    import bi_pkg::*;
#(
    parameter int unsigned DEPTH      = 2,
    parameter bit          INSTR_PORT = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              integ_en_i,
    input  logic              attr_integ_i,
    input  logic              req_i,
    input  logic              gnt_i,
    input  logic              gntpar_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        prot_i,
    input  logic [1:0]        memtype_i,
    input  logic [3:0]        be_i,
    input  logic              we_i,
    input  logic              dbg_i,
    input  logic [5:0]        atop_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rvalid_i,
    input  logic              rvalidpar_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              err_i,
    input  logic              exokay_i,
    input  logic [RCHK_W-1:0] rchk_i,
    output logic              reqpar_o,
    output logic [ACHK_W-1:0] achk_o,
    output logic              integ_err_o,
    output logic              alert_major_o
);
    logic chk_on, gnt_bad, rsp_bad, pending, orphan;
    txn_t new_txn, head;

    bi_achk_gen #(.INSTR_PORT(INSTR_PORT)) u_achk (
        .addr_i(addr_i), .prot_i(prot_i), .memtype_i(memtype_i), .be_i(be_i),
        .we_i(we_i), .dbg_i(dbg_i), .atop_i(atop_i), .wdata_i(wdata_i),
        .achk_o(achk_o)
    );

    // Request parity and grant-phase check with the two-level enable
    always_comb begin
        reqpar_o         = ~req_i;
        chk_on           = integ_en_i & attr_integ_i;
        gnt_bad          = req_i & chk_on & (gntpar_i == gnt_i);
        new_txn.is_write = INSTR_PORT ? 1'b0 : we_i;
        new_txn.chk_en   = chk_on;
    end

    bi_txn_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(req_i & gnt_i),
        .push_data_i(new_txn), .rvalid_i(rvalid_i), .pending_o(pending),
        .head_o(head), .orphan_o(orphan)
    );

    bi_rsp_check u_rsp (
        .pending_i(pending), .head_i(head), .rvalid_i(rvalid_i),
        .rvalidpar_i(rvalidpar_i), .rdata_i(rdata_i), .err_i(err_i),
        .exokay_i(exokay_i), .rchk_i(rchk_i), .bad_o(rsp_bad)
    );

    // Merge error sources into the two report outputs
    always_comb begin
        integ_err_o   = gnt_bad | rsp_bad;
        alert_major_o = integ_err_o | orphan;
    end

    assert_orphan_alerts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        orphan |-> alert_major_o);

    assert_orphan_unchecked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (orphan && !gnt_bad) |-> !rsp_bad);

    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pending && !chk_on) |-> !integ_err_o);

    assert_err_alerts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        integ_err_o |-> alert_major_o);
endmodule

// File: tb/bus_integrity_guard_test.sv
module bus_integrity_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic integ_en, attr, req, gnt, gntpar, we, dbg, rvalid, rvalidpar, err, exokay;
    logic [31:0] addr, wdata, rdata;
    logic [2:0] prot;
    logic [1:0] memtype;
    logic [3:0] be;
    logic [5:0] atop;
    logic [4:0] rchk;
    logic reqpar, ierr, alert, reqpar_i, ierr_i, alert_i;
    logic [11:0] achk, achk_i;
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    bus_integrity_guard uut (
        .clk_i(clk), .rst_ni(rst_n), .integ_en_i(integ_en), .attr_integ_i(attr),
        .req_i(req), .gnt_i(gnt), .gntpar_i(gntpar), .addr_i(addr), .prot_i(prot),
        .memtype_i(memtype), .be_i(be), .we_i(we), .dbg_i(dbg), .atop_i(atop),
        .wdata_i(wdata), .rvalid_i(rvalid), .rvalidpar_i(rvalidpar), .rdata_i(rdata),
        .err_i(err), .exokay_i(exokay), .rchk_i(rchk), .reqpar_o(reqpar),
        .achk_o(achk), .integ_err_o(ierr), .alert_major_o(alert)
    );

    bus_integrity_guard #(.INSTR_PORT(1'b1)) uut_instr (
        .clk_i(clk), .rst_ni(rst_n), .integ_en_i(integ_en), .attr_integ_i(attr),
        .req_i(req), .gnt_i(gnt), .gntpar_i(gntpar), .addr_i(addr), .prot_i(prot),
        .memtype_i(memtype), .be_i(be), .we_i(we), .dbg_i(dbg), .atop_i(atop),
        .wdata_i(wdata), .rvalid_i(rvalid), .rvalidpar_i(rvalidpar), .rdata_i(rdata),
        .err_i(err), .exokay_i(exokay), .rchk_i(rchk), .reqpar_o(reqpar_i),
        .achk_o(achk_i), .integ_err_o(ierr_i), .alert_major_o(alert_i)
    );

    function automatic logic par_n(input logic [31:0] v, input int nbits);
        int ones = 0;
        for (int i = 0; i < nbits; i++) ones += v[i];
        return (ones % 2) == 1;
    endfunction

    function automatic logic [3:0] bytes_par(input logic [31:0] v);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) r[b] = par_n(32'(v >> (8 * b)), 8);
        return r;
    endfunction

    function automatic logic [4:0] good_rchk(input logic [31:0] d, input logic e, input logic x);
        return {e ^ x, bytes_par(d)};
    endfunction

    task automatic check(input logic [11:0] got, input logic [11:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        req = 0; gnt = 0; gntpar = 1; rvalid = 0; rvalidpar = 1;
        rdata = 0; err = 0; exokay = 0; rchk = good_rchk(0, 0, 0);
    endtask

    // one grant cycle; expect no error unless a concurrent response is set up
    task automatic issue(input logic w, input logic en, input logic at);
        @(negedge clk);
        req = 1; gnt = 1; gntpar = 0; we = w; integ_en = en; attr = at;
        #2 check({10'b0, ierr, alert}, 12'b0, "R9 grant cycle quiet");
        @(posedge clk); #1 idle();
    endtask

    task automatic respond(input logic [31:0] d, input logic e, input logic [4:0] flip,
                           input logic rvp_bad, input logic exp_e, input logic exp_a,
                           input string tag);
        @(negedge clk);
        rvalid = 1; rvalidpar = rvp_bad; rdata = d; err = e; exokay = 0;
        rchk = good_rchk(d, e, 0) ^ flip;
        #2 check({10'b0, ierr, alert}, {10'b0, exp_e, exp_a}, tag);
        @(posedge clk); #1 idle();
    endtask

    initial begin
        #1990000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        integ_en = 1; attr = 1; addr = 0; prot = 0; memtype = 0; be = 0; we = 0;
        dbg = 0; atop = 0; wdata = 0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state: quiet outputs, queue empty (first rvalid is orphan)
        @(negedge clk);
        check({10'b0, ierr, alert}, 12'b0, "R11 reset quiet");
        respond(32'h0, 0, 5'h0, 0, 0, 1, "R10 orphan after reset");

        // R1 request parity, both levels
        @(negedge clk); req = 0; #1 check({11'b0, reqpar}, 12'h1, "R1 req=0");
        req = 1; gnt = 0; gntpar = 1; #1 check({11'b0, reqpar}, 12'h0, "R1 req=1");
        idle();

        // R2/R4 address and write-data byte parity sweep
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            addr = 32'(i) * 32'h9E37_79B9;
            wdata = ~addr ^ (32'(i) << 3);
            we = i[0]; be = 4'(i);
            #1;
            check({8'b0, achk[3:0]}, {8'b0, bytes_par(addr)}, "R2 addr bytes");
            check({8'b0, achk[11:8]}, {8'b0, bytes_par(wdata)}, "R4 wdata bytes");
        end

        // R3 exhaustive sweep of attribute fields
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            {prot, memtype} = 5'(i); {be, we} = 5'(i * 7); atop = 6'(i); dbg = i[1];
            #1;
            check({11'b0, achk[4]}, {11'b0, ~par_n(32'({prot, memtype}), 5)}, "R3 prot/memtype odd");
            check({11'b0, achk[5]}, {11'b0, ~par_n(32'({be, we}), 5)}, "R3 be/we odd");
            check({11'b0, achk[6]}, {11'b0, ~dbg}, "R3 dbg odd");
            check({11'b0, achk[7]}, {11'b0, par_n(32'(atop), 6)}, "R3 atop even");
        end

        // R12 instruction variant ignores write-side fields
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            addr = 32'h1 << i; wdata = 32'hA5C3_0F11 + 32'(i); we = 1; be = 4'(i);
            atop = 6'(i + 1); dbg = i[0]; {prot, memtype} = 5'(i);
            #1;
            check(achk_i, {4'b0, 1'b0, ~dbg, 1'b1, ~par_n(32'({prot, memtype}), 5),
                           bytes_par(addr)}, "R12 instr checksum");
        end
        we = 0;

        // R5 grant parity sweep over enables, grant and parity
        for (int i = 0; i < 16; i++) begin
            logic en, at, g, gp;
            {en, at, g, gp} = 4'(i);
            @(negedge clk);
            req = 1; gnt = g; gntpar = gp; integ_en = en; attr = at; we = 0;
            #2 check({10'b0, ierr, alert}, {10'b0, {2{en & at & (gp == g)}}}, "R5 grant parity");
            @(posedge clk); #1 idle();
            if (g) respond(32'h1234_5678, 0, 5'h0, 0, 0, 0, "R9 drain grant");
        end
        integ_en = 1; attr = 1;

        // R6 response-valid parity while pending, with and without rvalid
        issue(0, 1, 1);
        @(negedge clk); rvalidpar = 0;
        #2 check({10'b0, ierr, alert}, 12'h3, "R6 bad rvalidpar idle");
        rvalidpar = 1;
        respond(32'hDEAD_BEEF, 0, 5'h0, 1, 1, 1, "R6 bad rvalidpar on response");
        @(negedge clk); rvalidpar = 0;
        #2 check({10'b0, ierr, alert}, 12'h0, "R6 unchecked when empty");
        idle();

        // R7 read checksum: each data byte bit and the flag bit
        for (int b = 0; b < 5; b++) begin
            issue(0, 1, 1);
            respond(32'h0F1E_2D3C, b[0], 5'h1 << b, 0, 1, 1, "R7 read rchk flipped");
        end
        issue(0, 1, 1);
        respond(32'h8001_7FFE, 1, 5'h0, 0, 0, 0, "R7 read rchk good");
        // write: data bits ignored, flag bit checked
        issue(1, 1, 1);
        respond(32'h5555_AAAA, 0, 5'h0F, 0, 0, 0, "R7 write ignores data rchk");
        issue(1, 1, 1);
        respond(32'h5555_AAAA, 0, 5'h10, 0, 1, 1, "R7 write flag rchk flipped");

        // R8 captured enables: attr off, global off, global dropped later
        issue(0, 1, 0);
        respond(32'h1, 0, 5'h1F, 1, 0, 0, "R8 attr-disabled silent");
        issue(0, 0, 1);
        respond(32'h1, 0, 5'h1F, 1, 0, 0, "R8 global-disabled silent");
        issue(0, 1, 1);
        integ_en = 0;
        respond(32'h1, 0, 5'h01, 0, 1, 1, "R8 enable captured at grant");
        integ_en = 1;

        // R9 FIFO order and saturation: disabled, enabled, then an unrecorded third
        issue(0, 0, 1);
        issue(0, 1, 1);
        issue(0, 1, 1);
        respond(32'h2, 0, 5'h01, 0, 0, 0, "R9 first response uses disabled entry");
        respond(32'h2, 0, 5'h01, 0, 1, 1, "R9 second response uses enabled entry");
        respond(32'h2, 0, 5'h00, 0, 0, 1, "R9 third grant not recorded");

        // concurrent pop and push with one outstanding
        issue(0, 1, 1);
        @(negedge clk);
        req = 1; gnt = 1; gntpar = 0; we = 1; integ_en = 0;
        rvalid = 1; rvalidpar = 0; rdata = 32'h77; rchk = good_rchk(32'h77, 0, 0);
        #2 check({10'b0, ierr, alert}, 12'h0, "R9 pop+push same cycle");
        @(posedge clk); #1 idle(); integ_en = 1;
        respond(32'h3, 0, 5'h1F, 0, 0, 0, "R9 pushed disabled entry retired");
        respond(32'h3, 0, 5'h00, 0, 0, 1, "R9 queue empty after pop+push");

        // R10 orphan coinciding with a grant
        @(negedge clk);
        req = 1; gnt = 1; gntpar = 0; we = 0; rvalid = 1; rvalidpar = 0;
        #2 check({10'b0, ierr, alert}, 12'h1, "R10 orphan with grant");
        @(posedge clk); #1 idle();
        respond(32'h4, 0, 5'h00, 0, 0, 0, "R10 grant recorded despite orphan");
        respond(32'h4, 0, 5'h1F, 1, 0, 1, "R10 orphan performs no checks");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule